// File: doc/BRIEF.md
# Calendar Clock with Alarm

This block is a memory-mapped calendar clock. It keeps the month, day, hour, minute, second and a tenth-of-second count in one packed 32-bit time word, and it keeps the year as a plain binary number in a separate register. A prescaler divides the reference clock down to tenth-second steps. Each step advances the calendar. Seconds, minutes and hours wrap normally, days wrap at the true length of the month, and the year carries when December ends.

Software uses a 32-bit register bus to load the time and year, read them back, program an alarm word and set a control word. The alarm word packs the same calendar fields in a different layout and holds only the low six bits of the year. A single interrupt line pulses for one cycle when the clock reaches the alarm time, provided the alarm enable bit is set. If software writes an alarm time that has only just passed, the interrupt fires at once rather than being missed.

Top module: `calendar_rtc`

## Requirements
- R1: After reset, the time word reads 0x0420_0000 (month 1, day 1, all other fields zero). The year, the control word and all three alarm words read zero, and the interrupt output is low.
- R2: The time word at offset 0x24 (write) and 0x2C (read) packs month in [31:26], day in [25:21], hour in [20:16], minute in [15:10], second in [9:4] and tenths in [3:0]; month and day are 1-based. A write loads all fields at once, forces tenths to 0 whatever bits [3:0] carry, and restarts the prescaler.
- R3: A write to offset 0x28 sets the year, which reads back at 0x30 as a plain zero-extended binary value; it leaves the time word unchanged.
- R4: The tenths field steps by one every TENTH_DIV clocks counted from the last time-word write, and it counts 0 through 9 before it wraps to 0 with a one-second carry.
- R5: Seconds and minutes wrap from 59 to 0, and hours wrap from 23 to 0; each wrap carries into the next field.
- R6: The day wraps to 1 after day 30 in April, June, September and November, after day 28 in February (day 29 when the year is a multiple of 4), and after day 31 in all other months; the month then advances, and December wraps to January with the year incremented.
- R7: The alarm word at offset 0x34 packs year-low in [31:26], month in [25:22], day in [21:17], hour in [16:12], minute in [11:6] and second in [5:0]. It matches when every field equals the current time, with only the low 6 bits of the year compared.
- R8: When a one-second carry lands the time on a matching alarm, the interrupt pulses high for exactly one clock in the following cycle, but only while bit 11 of the control word (offset 0x40) is 1.
- R9: Writing the alarm word while the enable bit is set raises the interrupt in the next cycle if the day, month and year-low fields equal the current ones and the current time of day is 0 to 4 seconds after the alarm's. An alarm 5 or more seconds in the past, or one still in the future, does not fire on the write.
- R10: Control bits 11 and 13 are read/write; all other control bits read 0. Bit 13 has no other effect. The alarm words at 0x38 and 0x3C are plain 32-bit read/write storage.
- R11: Reads of any offset other than 0x2C, 0x30, 0x34, 0x38, 0x3C and 0x40 return 0, and writes to the read-only offsets 0x2C and 0x30 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe, one full 32-bit word per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| alarm_irq | output | 1 | One-cycle alarm interrupt pulse |

## Verification
The calendar is loaded with random legal dates and times, biased toward the last second of a minute, hour, day and month. It then runs for a random number of tenths and is compared against a bench model, which shows whether the carry chain and the month-length table agree over many starting points. Directed starting points at the end of February in leap and non-leap years, at the end of a 30-day month and at year end separate the leap rule from the plain month lengths. Alarm cases pair a match reached by counting with matches created by writing the alarm 3, 4 and 5 seconds late or 2 seconds early, and they toggle the enable bit and the year-low field. This tells apart a correct comparison window, an off-by-one window edge and a missing year-low compare.

// File: rtl/cal_pkg.sv
// Package: shared register offsets, packed word layouts and calendar
// helper functions for the calendar clock block.
// Assumes byte offsets within a 256-byte window and full-word accesses.
package cal_pkg;

    localparam int unsigned ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_TIME_WR = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_YEAR_WR = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_TIME_RD = 8'h2C;
    localparam logic [ADDR_W-1:0] OFS_YEAR_RD = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_ALM_CMP = 8'h34;
    localparam logic [ADDR_W-1:0] OFS_ALM_SP1 = 8'h38;
    localparam logic [ADDR_W-1:0] OFS_ALM_SP2 = 8'h3C;
    localparam logic [ADDR_W-1:0] OFS_CTRL    = 8'h40;

    localparam int unsigned CTRL_EN_BIT  = 11;
    localparam int unsigned CTRL_AUX_BIT = 13;

    // Packed time word, most significant field first
    typedef struct packed {
        logic [5:0] mon;
        logic [4:0] day;
        logic [4:0] hour;
        logic [5:0] min;
        logic [5:0] sec;
        logic [3:0] tenth;
    } cal_time_t;

    // Packed alarm word, most significant field first
    typedef struct packed {
        logic [5:0] yr_lo;
        logic [3:0] mon;
        logic [4:0] day;
        logic [4:0] hour;
        logic [5:0] min;
        logic [5:0] sec;
    } cal_alarm_t;

    // Last day number of a month; leap selects 29 for February
    function automatic logic [4:0] month_len(input logic [5:0] mon, input logic leap);
        logic [4:0] len;
        case (mon)
            6'd2:                     len = leap ? 5'd29 : 5'd28;
            6'd4, 6'd6, 6'd9, 6'd11:  len = 5'd30;
            default:                  len = 5'd31;
        endcase
        return len;
    endfunction

    // Seconds elapsed since midnight
    function automatic logic [16:0] day_secs(input logic [4:0] h, input logic [5:0] m,
                                             input logic [5:0] s);
        return 17'(h) * 17'd3600 + 17'(m) * 17'd60 + 17'(s);
    endfunction

endpackage

// File: rtl/cal_tenth_gen.sv
// Module: tenth-second strobe generator.
// Divides the reference clock by DIV and emits a one-cycle tick on the
// last count. A clear restarts the count from zero (no tick that cycle).
// Assumes DIV >= 1.
module cal_tenth_gen #(
    parameter int unsigned DIV = 12_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    // Tick on the final count unless being restarted
    assign tick = (cnt_q == LAST) && !clr;

    // Divider counter with restart
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/cal_time_core.sv
// Module: calendar datapath.
// Holds the packed time word and the binary year, loads them from the
// bus, and advances them by one tenth per tick through the full carry
// chain (tenths, seconds, minutes, hours, days, months, year).
// Emits a registered strobe in the cycle after a second has elapsed.
// Assumes YEAR_W >= 2; leap years are those with the low two bits zero.
module cal_time_core
    import cal_pkg::*;
#(
    parameter int unsigned YEAR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              ld_time,
    input  logic              ld_year,
    input  logic [31:0]       wdata,
    output cal_time_t         time_o,
    output logic [YEAR_W-1:0] year_o,
    output logic              sec_step_o
);
    cal_time_t         t_q;
    logic [YEAR_W-1:0] year_q;
    logic              step_q;

    cal_time_t         t_nx;
    logic              c_sec, c_min, c_hour, c_day, c_mon, c_year;
    logic [4:0]        mlen;

    // Carry chain: each stage wraps and carries only if the stage below carried
    always_comb begin
        mlen   = month_len(t_q.mon, year_q[1:0] == 2'b00);
        c_sec  = tick  && (t_q.tenth >= 4'd9);
        c_min  = c_sec && (t_q.sec  >= 6'd59);
        c_hour = c_min && (t_q.min  >= 6'd59);
        c_day  = c_hour && (t_q.hour >= 5'd23);
        c_mon  = c_day && (t_q.day  >= mlen);
        c_year = c_mon && (t_q.mon  >= 6'd12);

        t_nx = t_q;
        if (tick)   t_nx.tenth = c_sec  ? 4'd0 : t_q.tenth + 4'd1;
        if (c_sec)  t_nx.sec   = c_min  ? 6'd0 : t_q.sec   + 6'd1;
        if (c_min)  t_nx.min   = c_hour ? 6'd0 : t_q.min   + 6'd1;
        if (c_hour) t_nx.hour  = c_day  ? 5'd0 : t_q.hour  + 5'd1;
        if (c_day)  t_nx.day   = c_mon  ? 5'd1 : t_q.day   + 5'd1;
        if (c_mon)  t_nx.mon   = c_year ? 6'd1 : t_q.mon   + 6'd1;
    end

    // Time word register: bus load wins over counting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '{mon: 6'd1, day: 5'd1, default: '0};
        end else if (ld_time) begin
            t_q <= cal_time_t'({wdata[31:4], 4'd0});
        end else begin
            t_q <= t_nx;
        end
    end

    // Year register: bus load wins over the December carry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            year_q <= '0;
        end else if (ld_year) begin
            year_q <= wdata[YEAR_W-1:0];
        end else if (c_year && !ld_time) begin
            year_q <= year_q + 1'b1;
        end
    end

    // Strobe marking that the seconds field has just advanced
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= 1'b0;
        end else begin
            step_q <= c_sec && !ld_time;
        end
    end

    assign time_o     = t_q;
    assign year_o     = year_q;
    assign sec_step_o = step_q;
endmodule

// File: rtl/cal_alarm_unit.sv
// Module: alarm comparator and interrupt pulse generator.
// Fires on an exact match in the cycle after a second step, or in the
// cycle after an alarm write when the alarm lies 0..4 s in the past on
// the same date. The output is a registered one-cycle pulse gated by the
// enable bit. Assumes the alarm register updates on the write edge.
module cal_alarm_unit
    import cal_pkg::*;
#(
    parameter int unsigned LATE_SECS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       alm_wr,
    input  logic       sec_step,
    input  cal_alarm_t alarm,
    input  logic [5:0] cur_mon,
    input  logic [4:0] cur_day,
    input  logic [4:0] cur_hour,
    input  logic [5:0] cur_min,
    input  logic [5:0] cur_sec,
    input  logic [5:0] cur_yr_lo,
    output logic       irq
);
    localparam logic signed [17:0] LATE_MAX = 18'(LATE_SECS);

    logic              wr_pend_q;
    logic              irq_q;
    logic              date_eq, exact_eq, late_ok;
    logic signed [17:0] sec_diff;

    // Field comparison and late-write window
    always_comb begin
        date_eq  = (alarm.yr_lo == cur_yr_lo) && ({2'b00, alarm.mon} == cur_mon) &&
                   (alarm.day == cur_day);
        exact_eq = date_eq && (alarm.hour == cur_hour) && (alarm.min == cur_min) &&
                   (alarm.sec == cur_sec);
        sec_diff = $signed({1'b0, day_secs(cur_hour, cur_min, cur_sec)}) -
                   $signed({1'b0, day_secs(alarm.hour, alarm.min, alarm.sec)});
        late_ok  = date_eq && !sec_diff[17] && (sec_diff <= LATE_MAX);
    end

    // Remember an alarm write for evaluation against the new alarm value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_pend_q <= 1'b0;
        end else begin
            wr_pend_q <= alm_wr;
        end
    end

    // Registered interrupt pulse, never two cycles in a row
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= en && !irq_q && ((sec_step && exact_eq) || (wr_pend_q && late_ok));
        end
    end

    assign irq = irq_q;
endmodule

// File: rtl/calendar_rtc.sv
// Module: calendar clock top level.
// Decodes the 32-bit register bus, holds the alarm and control words,
// and ties together the prescaler, calendar datapath and alarm unit.
// Assumes full-word accesses at exact byte offsets; reads are
// combinational on bus_addr. Requires 6 <= YEAR_W <= 32.
module calendar_rtc
    import cal_pkg::*;
#(
    parameter int unsigned TENTH_DIV = 12_500_000,
    parameter int unsigned YEAR_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              alarm_irq
);
    logic              wr_time, wr_year, wr_alm, wr_sp1, wr_sp2, wr_ctrl;
    logic              tenth_tick;
    logic              sec_step;
    cal_time_t         cur_time;
    logic [31:0]       time_word;
    logic [YEAR_W-1:0] cur_year;
    cal_alarm_t        alarm_q;
    logic [31:0]       spare1_q, spare2_q;
    logic              ctrl_en_q, ctrl_aux_q;

    // Write strobes, one per writable offset
    always_comb begin
        wr_time = bus_we && (bus_addr == OFS_TIME_WR);
        wr_year = bus_we && (bus_addr == OFS_YEAR_WR);
        wr_alm  = bus_we && (bus_addr == OFS_ALM_CMP);
        wr_sp1  = bus_we && (bus_addr == OFS_ALM_SP1);
        wr_sp2  = bus_we && (bus_addr == OFS_ALM_SP2);
        wr_ctrl = bus_we && (bus_addr == OFS_CTRL);
    end

    cal_tenth_gen #(.DIV(TENTH_DIV)) u_tenth (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (wr_time),
        .tick  (tenth_tick)
    );

    cal_time_core #(.YEAR_W(YEAR_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tenth_tick),
        .ld_time    (wr_time),
        .ld_year    (wr_year),
        .wdata      (bus_wdata),
        .time_o     (cur_time),
        .year_o     (cur_year),
        .sec_step_o (sec_step)
    );

    assign time_word = cur_time;

    // Alarm compare word and the two storage-only alarm words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_q  <= '0;
            spare1_q <= '0;
            spare2_q <= '0;
        end else begin
            if (wr_alm) alarm_q  <= cal_alarm_t'(bus_wdata);
            if (wr_sp1) spare1_q <= bus_wdata;
            if (wr_sp2) spare2_q <= bus_wdata;
        end
    end

    // Control word: enable bit and a storage-only bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_en_q  <= 1'b0;
            ctrl_aux_q <= 1'b0;
        end else if (wr_ctrl) begin
            ctrl_en_q  <= bus_wdata[CTRL_EN_BIT];
            ctrl_aux_q <= bus_wdata[CTRL_AUX_BIT];
        end
    end

    cal_alarm_unit u_alarm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (ctrl_en_q),
        .alm_wr    (wr_alm),
        .sec_step  (sec_step),
        .alarm     (alarm_q),
        .cur_mon   (cur_time.mon),
        .cur_day   (cur_time.day),
        .cur_hour  (cur_time.hour),
        .cur_min   (cur_time.min),
        .cur_sec   (cur_time.sec),
        .cur_yr_lo (cur_year[5:0]),
        .irq       (alarm_irq)
    );

    // Read mux; unmapped and write-only offsets read zero
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_TIME_RD: bus_rdata = time_word;
            OFS_YEAR_RD: bus_rdata = 32'(cur_year);
            OFS_ALM_CMP: bus_rdata = alarm_q;
            OFS_ALM_SP1: bus_rdata = spare1_q;
            OFS_ALM_SP2: bus_rdata = spare2_q;
            OFS_CTRL: begin
                bus_rdata[CTRL_EN_BIT]  = ctrl_en_q;
                bus_rdata[CTRL_AUX_BIT] = ctrl_aux_q;
            end
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/cal_rtc_chk.sv
// Module: assertion checker for the calendar clock, bound to the top.
// Observes the bus read path, the interrupt, the enable bit and the
// tenths field. Assumes synchronous active-low reset.
module cal_rtc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] bus_addr,
    input logic [31:0] bus_rdata,
    input logic       irq,
    input logic       en,
    input logic [3:0] tenth
);
    // R8
    irq_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R8
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(en));

    // R4
    tenth_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tenth <= 4'd9);

    // R4
    tenth_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tenth) |-> ((tenth == 4'($past(tenth) + 4'd1)) || (tenth == 4'd0)));

    // R11
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_addr == 8'h20) || (bus_addr == 8'h24) || (bus_addr == 8'h00) ||
         (bus_addr == 8'h44)) |-> (bus_rdata == 32'd0));

    // R10
    ctrl_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 8'h40) |-> ((bus_rdata & ~32'h0000_2800) == 32'd0));
endmodule

bind calendar_rtc cal_rtc_chk u_cal_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq       (alarm_irq),
    .en        (ctrl_en_q),
    .tenth     (time_word[3:0])
);

// File: tb/calendar_rtc_bench.sv
// Bench: directed corner cases plus seeded random calendar runs,
// checked against a bench-side calendar model.
module calendar_rtc_bench;
    localparam int D = 2;

    typedef struct {
        int mon, day, hour, min, sec, tenth, year;
    } tm_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        alarm_irq;

    int checks = 0;
    int errors = 0;
    int irq_seen = 0;
    bit done = 0;

    calendar_rtc #(.TENTH_DIV(D), .YEAR_W(16)) u_calendar_rtc (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .alarm_irq(alarm_irq)
    );

    always #4 clk = ~clk;

    always @(negedge clk) if (alarm_irq === 1'b1) irq_seen++;

    function automatic int mdays(int mon, int year);
        if (mon == 2) return (year % 4 == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    function automatic tm_t adv(tm_t t, int n);
        for (int i = 0; i < n; i++) begin
            t.tenth++;
            if (t.tenth == 10) begin
                t.tenth = 0; t.sec++;
                if (t.sec == 60) begin
                    t.sec = 0; t.min++;
                    if (t.min == 60) begin
                        t.min = 0; t.hour++;
                        if (t.hour == 24) begin
                            t.hour = 0; t.day++;
                            if (t.day > mdays(t.mon, t.year)) begin
                                t.day = 1; t.mon++;
                                if (t.mon == 13) begin t.mon = 1; t.year++; end
                            end
                        end
                    end
                end
            end
        end
        return t;
    endfunction

    function automatic logic [31:0] tword(tm_t t);
        return {6'(t.mon), 5'(t.day), 5'(t.hour), 6'(t.min), 6'(t.sec), 4'(t.tenth)};
    endfunction

    function automatic logic [31:0] aword(int yr, int mon, int day, int h, int m, int s);
        return {6'(yr), 4'(mon), 5'(day), 5'(h), 6'(m), 6'(s)};
    endfunction

    function automatic tm_t mk(int y, int mo, int d, int h, int mi, int s);
        tm_t t;
        t.year = y; t.mon = mo; t.day = d; t.hour = h; t.min = mi; t.sec = s; t.tenth = 0;
        return t;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Write: call between a negedge and the next posedge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // Load time (edge w) then year (edge w+1)
    task automatic set_all(input tm_t t);
        wr(8'h24, tword(t));
        wr(8'h28, 32'(t.year));
    endtask

    // After set_all: run until n tenths have elapsed since the time write
    task automatic run_tenths(input int n);
        repeat (n * D - 1) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_now(input string req, input tm_t exp);
        logic [31:0] v;
        rd(8'h2C, v); chk(req, v, tword(exp));
        rd(8'h30, v); chk(req, v, 32'(exp.year));
    endtask

    task automatic roll(input string req, input tm_t t, input int n);
        set_all(t);
        run_tenths(n);
        check_now(req, adv(t, n));
    endtask

    task automatic irq_window(input string req, input int cyc, input int exp);
        int base;
        base = irq_seen;
        repeat (cyc) @(negedge clk);
        chk(req, 32'(irq_seen - base), 32'(exp));
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        tm_t t;
        void'($urandom(32'd20240615));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(8'h2C, v); chk("R1 time", v, 32'h0420_0000);
        rd(8'h30, v); chk("R1 year", v, 32'd0);
        @(negedge clk);
        rd(8'h40, v); chk("R1 ctrl", v, 32'd0);
        rd(8'h34, v); chk("R1 alarm", v, 32'd0);
        @(negedge clk);
        chk("R1 irq", 32'(alarm_irq), 32'd0);

        // R2 load with tenths bits set, R3 year write leaves time alone
        t = mk(2023, 7, 19, 13, 45, 12);
        wr(8'h24, tword(t) | 32'hF);
        rd(8'h2C, v); chk("R2 load clears tenths", v, tword(t));
        wr(8'h28, 32'd1999);
        rd(8'h2C, v); chk("R3 time unchanged", v, tword(t));
        rd(8'h30, v); chk("R3 year", v, 32'd1999);

        // R11 writes to read-only offsets ignored
        wr(8'h24, tword(t));
        wr(8'h2C, 32'hFFFF_FFFF);
        rd(8'h2C, v); chk("R11 time ro", v, tword(t));
        wr(8'h30, 32'h1234);
        rd(8'h30, v); chk("R11 year ro", v, 32'd1999);
        @(negedge clk);
        rd(8'h20, v); chk("R11 trim reads 0", v, 32'd0);
        rd(8'h24, v); chk("R11 wr-only reads 0", v, 32'd0);
        @(negedge clk);
        rd(8'hFC, v); chk("R11 top reads 0", v, 32'd0);

        // R10 control and storage words
        wr(8'h40, 32'hFFFF_FFFF);
        rd(8'h40, v); chk("R10 ctrl bits", v, 32'h0000_2800);
        wr(8'h38, 32'hA5C3_0F11);
        wr(8'h3C, 32'h5A3C_F0EE);
        rd(8'h38, v); chk("R10 spare1", v, 32'hA5C3_0F11);
        rd(8'h3C, v); chk("R10 spare2", v, 32'h5A3C_F0EE);
        wr(8'h40, 32'h0000_2000);
        rd(8'h40, v); chk("R10 aux only", v, 32'h0000_2000);

        // R4 tenths stepping and carry into seconds
        t = mk(2023, 3, 3, 3, 3, 3);
        set_all(t); run_tenths(3); check_now("R4 three tenths", adv(t, 3));
        set_all(t); run_tenths(9); check_now("R4 nine tenths", adv(t, 9));
        set_all(t); run_tenths(10); check_now("R4 tenth wrap", adv(t, 10));

        // R5 second/minute/hour wraps
        roll("R5 minute wrap", mk(2023, 5, 9, 7, 12, 59), 10);
        roll("R5 hour wrap", mk(2023, 5, 9, 7, 59, 59), 10);
        roll("R5 day carry", mk(2023, 5, 9, 23, 59, 59), 10);

        // R6 month lengths, leap rule, year carry
        roll("R6 feb nonleap", mk(2023, 2, 28, 23, 59, 59), 10);
        roll("R6 feb leap 28", mk(2024, 2, 28, 23, 59, 59), 10);
        roll("R6 feb leap 29", mk(2024, 2, 29, 23, 59, 59), 10);
        roll("R6 april", mk(2023, 4, 30, 23, 59, 59), 10);
        roll("R6 july 30", mk(2023, 7, 30, 23, 59, 59), 10);
        roll("R6 year end", mk(2023, 12, 31, 23, 59, 59), 12);

        // R7 R8 alarm reached by counting
        t = mk(2024, 6, 15, 8, 30, 41);
        wr(8'h40, 32'd0);
        wr(8'h34, aword(2024 % 64, 6, 15, 8, 30, 42));
        rd(8'h34, v); chk("R7 alarm readback", v, aword(40, 6, 15, 8, 30, 42));
        set_all(t);
        wr(8'h40, 32'h800);
        irq_window("R8 fires once on match", 30, 1);

        wr(8'h40, 32'd0);
        set_all(t);
        irq_window("R8 disabled no pulse", 30, 0);

        wr(8'h40, 32'h800);
        wr(8'h34, aword(41, 6, 15, 8, 30, 50));
        set_all(t);
        wr(8'h34, aword(41, 6, 15, 8, 30, 42));
        irq_window("R7 year-low mismatch", 30, 0);

        t.year = 2088;
        wr(8'h40, 32'd0);
        wr(8'h34, aword(40, 6, 15, 8, 30, 42));
        set_all(t);
        wr(8'h40, 32'h800);
        irq_window("R7 only low 6 year bits", 30, 1);

        // R9 late alarm writes
        t = mk(2024, 6, 15, 10, 20, 30);
        set_all(t); wr(8'h34, aword(40, 6, 15, 10, 20, 27));
        irq_window("R9 3s late fires", 4, 1);
        set_all(t); wr(8'h34, aword(40, 6, 15, 10, 20, 26));
        irq_window("R9 4s late fires", 4, 1);
        set_all(t); wr(8'h34, aword(40, 6, 15, 10, 20, 25));
        irq_window("R9 5s late silent", 4, 0);
        set_all(t); wr(8'h34, aword(40, 6, 15, 10, 20, 32));
        irq_window("R9 future silent", 4, 0);
        wr(8'h40, 32'd0);

        // R4 R5 R6 random runs against the model
        for (int i = 0; i < 40; i++) begin
            tm_t r;
            r.year  = $urandom_range(1970, 2400);
            r.mon   = $urandom_range(1, 12);
            r.day   = ($urandom_range(0, 1) == 1) ? mdays(r.mon, r.year)
                                                 : $urandom_range(1, mdays(r.mon, r.year));
            r.hour  = ($urandom_range(0, 1) == 1) ? 23 : $urandom_range(0, 23);
            r.min   = ($urandom_range(0, 1) == 1) ? 59 : $urandom_range(0, 59);
            r.sec   = ($urandom_range(0, 3) != 0) ? 59 : $urandom_range(0, 59);
            r.tenth = 0;
            roll("R6 random calendar", r, $urandom_range(1, 25));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule